// File: doc/BRIEF.md
# Break-Protected Status Flag Bank

This block holds a bank of sticky status flags behind a small register bus. Each flag is set by a one-cycle event from a peripheral and is cleared by a two-step software sequence. The first step is a read of the shared status register that returns the flag as 1, which arms the flag. The second step is any read or write of that flag's own data register, which clears the armed flag.

While a debug halt (break) is active, a debugger must be able to inspect and change registers without losing status information. The block therefore treats every clearing step as protected whenever break is active and the clear-enable control bit is 0. Reads and writes still complete in the normal way, but no flag is cleared, no flag becomes armed, and no armed flag is disarmed. A first step taken before break stays pending through the break, so the second step still clears the flag after break ends. When the clear-enable bit is 1, clearing during break works as it does outside break, and a flag cleared this way stays cleared afterwards.

The bus has no back-pressure. Every access completes in the cycle its strobe is high. Read data is combinational during that cycle, and state changes take effect at the clock edge that ends it.

Top module: `brk_flag_guard`

## Requirements
- R1: After a synchronous active-high reset, all flags, all armed bits, the clear-enable bit and all data registers are 0.
- R2: A set event on flag i makes flag i read 1 after the next clock edge. A set event in the same cycle as a completing second step keeps the flag at 1.
- R3: A read of the status register at address 0 returns flag i in bit i, with the upper bits 0. When the read is not protected, it arms every flag that reads as 1.
- R4: A read or write of data register i at address 2+i, when flag i is armed and the access is not protected, clears flag i and its armed bit at the next clock edge.
- R5: An access to data register i while flag i is not armed leaves flag i unchanged.
- R6: While break is active with clear-enable at 0, no flag is cleared. Data register writes are still stored, and reads still return the stored value.
- R7: An arm made before break survives a protected second step during break. After break ends, a second step clears the flag.
- R8: With clear-enable at 1 during break, an armed second step clears the flag, and the flag stays 0 after break ends.
- R9: Bit 0 of the control register at address 1 is the clear-enable bit. A write stores it, and a read returns it in bit 0 with the other bits 0.
- R10: A status read made while break is active with clear-enable at 0 does not arm any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_evt | input | NUM_FLAGS | One set pulse per flag |
| brk_active | input | 1 | Debug break state |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle bus_rd is high |
| flags | output | NUM_FLAGS | Current flag values |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it one time unit after it drives the strobe and before the rising edge. Flag and armed-state changes land at the edge that ends the access. The bench releases each access at the falling edge that follows and compares the flags there. Armed state is never read directly. It is judged by a later second step and the flag value that follows it, which covers arming before break, during break and with concurrent set events.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int STATUS_ADDR = 0;
  localparam int CTRL_ADDR   = 1;
  localparam int DATA_BASE   = 2;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_STATUS,
    ACC_CTRL,
    ACC_DATA
  } acc_kind_e;
endpackage

// File: rtl/bfp_decode.sv
module bfp_decode
  import bfp_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output acc_kind_e            kind,
  output logic [NUM_FLAGS-1:0] data_hit,
  output logic [NUM_FLAGS-1:0] data_wr
);
  logic acc;
  assign acc = rd | wr;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
    assign data_hit[i] = acc && (addr == ADDR_W'(DATA_BASE + i));
    assign data_wr[i]  = wr  && (addr == ADDR_W'(DATA_BASE + i));
  end

  always_comb begin
    kind = ACC_NONE;
    if (acc) begin
      if (addr == ADDR_W'(STATUS_ADDR))      kind = ACC_STATUS;
      else if (addr == ADDR_W'(CTRL_ADDR))   kind = ACC_CTRL;
      else if (|data_hit)                    kind = ACC_DATA;
    end
  end
endmodule

// File: rtl/bfp_flag_cell.sv
module bfp_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic allow_i,
  input  logic stat_rd_i,
  input  logic step2_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_q, arm_q, finish;

  assign finish = step2_i && allow_i && arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)       flag_q <= 1'b1;
      else if (finish) flag_q <= 1'b0;
      if (finish)                                arm_q <= 1'b0;
      else if (stat_rd_i && allow_i && flag_q)   arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;

  // R6
  prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !allow_i) |=> flag_q);
  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  // R4
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !arm_q) |=> flag_q);
  // R10
  no_arm_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (!arm_q && !allow_i) |=> !arm_q);
  // R7
  arm_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_q && !allow_i) |=> arm_q);
endmodule

// File: rtl/bfp_readback.sv
module bfp_readback
  import bfp_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                            rd,
  input  acc_kind_e                       kind,
  input  logic [NUM_FLAGS-1:0]            data_hit,
  input  logic [NUM_FLAGS-1:0]            flags,
  input  logic                            clr_en,
  input  logic [NUM_FLAGS-1:0][DATA_W-1:0] data_regs,
  output logic [DATA_W-1:0]               rdata
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (kind)
        ACC_STATUS: rdata = DATA_W'(flags);
        ACC_CTRL:   rdata = DATA_W'(clr_en);
        ACC_DATA: begin
          for (int i = 0; i < NUM_FLAGS; i++)
            if (data_hit[i]) rdata = data_regs[i];
        end
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/brk_flag_guard.sv
module brk_flag_guard
  import bfp_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_evt,
  input  logic                 brk_active,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_FLAGS-1:0] flags
);
  localparam int NUM_REGS = DATA_BASE + NUM_FLAGS;

  initial begin
    if (NUM_REGS > (1 << ADDR_W)) $error("address space too small");
    if (NUM_FLAGS > DATA_W)       $error("status register too narrow");
  end

  acc_kind_e                        kind;
  logic [NUM_FLAGS-1:0]             data_hit, data_wr, arm;
  logic [NUM_FLAGS-1:0][DATA_W-1:0] data_q;
  logic                             clr_en_q, allow, stat_rd;

  assign allow   = !brk_active || clr_en_q;
  assign stat_rd = bus_rd && (kind == ACC_STATUS);

  bfp_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .kind(kind), .data_hit(data_hit), .data_wr(data_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) clr_en_q <= 1'b0;
    else if (bus_wr && kind == ACC_CTRL) clr_en_q <= bus_wdata[0];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    bfp_flag_cell u_cell (
      .clk(clk), .rst(rst), .set_i(set_evt[i]), .allow_i(allow),
      .stat_rd_i(stat_rd), .step2_i(data_hit[i]),
      .flag_o(flags[i]), .arm_o(arm[i])
    );

    always_ff @(posedge clk) begin
      if (rst) data_q[i] <= '0;
      else if (data_wr[i]) data_q[i] <= bus_wdata;
    end

    // R6
    data_store_chk: assert property (@(posedge clk) disable iff (rst)
      data_wr[i] |=> data_q[i] == $past(bus_wdata));
    // R3
    arm_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
      arm[i] |-> flags[i]);
  end

  bfp_readback #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rb (
    .rd(bus_rd), .kind(kind), .data_hit(data_hit), .flags(flags),
    .clr_en(clr_en_q), .data_regs(data_q), .rdata(bus_rdata)
  );

  // R9
  ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kind == ACC_CTRL) |=> clr_en_q == $past(bus_wdata[0]));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == '0 && arm == '0 && !clr_en_q));
endmodule

// File: tb/brk_flag_guard_bench.sv
module brk_flag_guard_bench;
  logic       clk = 0, rst = 0, brk = 0, rd = 0, wr = 0;
  logic [3:0] set_evt = 0, flags;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, last_rd;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  brk_flag_guard u_brk_flag_guard (
    .clk(clk), .rst(rst), .set_evt(set_evt), .brk_active(brk),
    .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .flags(flags)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [2:0] a,
                      input logic [7:0] d, input logic [3:0] s);
    rd = r; wr = w; addr = a; wdata = d; set_evt = s;
    #1 last_rd = rdata;
    @(posedge clk); @(negedge clk);
    rd = 0; wr = 0; addr = 0; wdata = 0; set_evt = 0;
  endtask

  task automatic do_reset();
    rst = 1; brk = 0;
    step(0, 0, 0, 0, 0);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 4'hF);
    do_reset();
    chk("R1 flags", 8'(flags), 8'h00);
    step(1, 0, 3'd1, 0, 0); chk("R1 ctrl", last_rd, 8'h00);
    step(1, 0, 3'd3, 0, 0); chk("R1 data", last_rd, 8'h00);
    step(0, 1, 3'd1, 8'hFF, 0);
    step(1, 0, 3'd1, 0, 0); chk("R9 ctrl set", last_rd, 8'h01);
    step(0, 1, 3'd1, 8'hFE, 0);
    step(1, 0, 3'd1, 0, 0); chk("R9 ctrl clr", last_rd, 8'h00);

    // R10: protected status read must not arm
    do_reset();
    step(0, 0, 0, 0, 4'b0100);
    brk = 1;
    step(1, 0, 3'd0, 0, 0); chk("R3 status in break", last_rd, 8'h04);
    brk = 0;
    step(1, 0, 3'd4, 0, 0); chk("R10 no arm", 8'(flags), 8'h04);

    for (int b = 0; b < 2; b++)
    for (int c = 0; c < 2; c++)
    for (int a = 0; a < 2; a++)
    for (int w = 0; w < 2; w++)
    for (int s = 0; s < 2; s++)
    for (int i = 0; i < 4; i++) begin
      logic allow, f1, arm1, f2;
      logic [3:0] m, other;
      m = 4'(1 << i);
      other = m ^ 4'b1001;
      do_reset();
      step(0, 0, 0, 0, m | (other & 4'b0001));
      chk("R2 set", 8'(flags), 8'(m | (other & 4'b0001)));
      if (a != 0) begin
        step(1, 0, 3'd0, 0, 0);
        chk("R3 status", last_rd, 8'(m | (other & 4'b0001)));
      end
      if (c != 0) step(0, 1, 3'd1, 8'h01, 0);
      brk = (b != 0);
      allow = (b == 0) || (c != 0);
      step(w == 0, w != 0, 3'(2 + i), 8'hA0 | 8'(i), (s != 0) ? m : 4'b0);
      f1 = (s != 0) || !((a != 0) && allow);
      arm1 = (a != 0) && !allow;
      chk((s != 0) ? "R2 set wins" : (a == 0) ? "R5 unarmed" :
          !allow ? "R6 protected" : (b != 0) ? "R8 cen clears" : "R4 clear",
          8'(flags[i]), 8'(f1));
      if (w != 0) begin
        step(1, 0, 3'(2 + i), 0, 0);
        chk("R6 data kept", last_rd, 8'hA0 | 8'(i));
      end
      brk = 0;
      step(1, 0, 3'(2 + i), 0, 0);
      f2 = f1 && !arm1;
      chk(arm1 ? "R7 pending arm" : ((b != 0 && c != 0 && a != 0) ? "R8 stays clear" : "R5 after"),
          8'(flags[i]), 8'(f2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule